// File: doc/BRIEF.md
# Routed Interrupt Pin Controller

This block sits between the event sources of a serial data interface and the host. Each event condition arrives as a one-cycle strobe, and a small routing code picks which of the general-purpose active-low interrupt pins it drives. A code of zero leaves the condition unrouted. Every pin has its own latched status register, its own mask bit and its own choice between a held level and a fixed-length pulse. A status read strobe from the host clears the register that was read.

A separate active-low error pin follows a small error register. That register captures the rising edge of each error condition. A bit clears when the host reads the register or when its condition goes away. The error pin has no mask.

The address decode of the host bus is outside this block. The block takes read strobes and mode, mask and routing values as plain inputs, and it returns the register contents on plain outputs.

Top module: `irq_route_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every interrupt pin and the error pin are high, and every status bit is zero.
- R2: The routing code of condition c is the MAP_W-bit field starting at bit c*MAP_W of `evt_map`. A strobe on condition c with code k in 1..NUM_GP sets bit c of the status word for pin k-1, which occupies `gp_status[(k-1)*NUM_COND +: NUM_COND]`. No other status word changes. Code 0 sets nothing.
- R3: In level mode (mode bit 0), an unmasked pin is low from the clock edge that latches a status bit. It stays low until the edge at which a read strobe for that pin empties the status word.
- R4: If a routed event arrives in the same cycle as a read strobe for its pin, its status bit is still set after that read.
- R5: A mask bit of 1 holds its pin high while status keeps latching. In level mode, clearing the mask with status pending drives the pin low at the next edge.
- R6: In pulse mode (mode bit 1), an unmasked routed event drives the pin low for exactly PULSE_CYCLES cycles. The pin then returns high. Status still latches.
- R7: An event routed to a pin that is already pulsing does not lengthen or restart the pulse.
- R8: In pulse mode, an event that arrives while the pin is masked produces no pulse, either then or after the mask is cleared.
- R9: The error pin is low exactly when some error status bit is set, whatever the general-purpose masks hold.
- R10: An error status bit sets on a rising edge of its condition. It clears when `err_stat_rd` is strobed or when the condition goes low. A rising edge in the same cycle as the read leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | NUM_COND | One-cycle event strobes, one per condition |
| evt_map | input | NUM_COND*MAP_W | Routing code per condition (0 = unrouted) |
| gp_pulse_mode | input | NUM_GP | Per pin: 0 level mode, 1 pulse mode |
| gp_mask | input | NUM_GP | Per pin mask, 1 holds the pin inactive |
| gp_stat_rd | input | NUM_GP | Per pin status read strobe, clears that status word |
| err_cond | input | NUM_ERR | Error condition levels |
| err_stat_rd | input | 1 | Error status read strobe |
| gp_status | output | NUM_GP*NUM_COND | Latched status words, one per pin |
| err_status | output | NUM_ERR | Latched error status |
| irq_n | output | NUM_GP | Active-low general-purpose interrupt pins |
| err_n | output | 1 | Active-low error pin |

## Verification
The bench builds the block with four conditions, three error inputs, three pins and a pulse of five cycles. With only four conditions, each one can be routed to every pin and to none, and the resulting status word position can be checked exactly. The short pulse lets the bench count the full low time of a pulse. It also lets the bench land a second event in the middle of a pulse and still watch the pin return high. The three error inputs allow separate cases for clearing by read, clearing by removal of the condition, and a read that collides with a rising edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {IRQ_LEVEL = 1'b0, IRQ_PULSE = 1'b1} irq_mode_e;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irqc_router.sv
module irqc_router #(
  parameter int NUM_COND = 8,
  parameter int NUM_GP   = 3,
  parameter int MAP_W    = 2
) (
  input  logic [NUM_COND-1:0]        evt,
  input  logic [NUM_COND*MAP_W-1:0]  map,
  output logic [NUM_GP*NUM_COND-1:0] hits
);
  for (genvar g = 0; g < NUM_GP; g++) begin : g_out
    for (genvar c = 0; c < NUM_COND; c++) begin : g_cond
      assign hits[g*NUM_COND+c] = evt[c] && (map[c*MAP_W +: MAP_W] == MAP_W'(g+1));
    end
  end
endmodule

// File: rtl/irqc_gp_chan.sv
module irqc_gp_chan
  import irqc_pkg::*;
#(
  parameter int NUM_COND     = 8,
  parameter int PULSE_CYCLES = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_COND-1:0] hits,
  input  logic                pulse_mode,
  input  logic                mask,
  input  logic                rd,
  output logic [NUM_COND-1:0] status_q,
  output logic                irq_n_q
);
  localparam int CNT_W = cnt_width(PULSE_CYCLES);

  logic [NUM_COND-1:0] status_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                busy_q, busy_d;
  logic                start, level_low, pin_low;
  irq_mode_e           mode;

  assign mode      = irq_mode_e'(pulse_mode);
  assign status_d  = (status_q & ~{NUM_COND{rd}}) | hits;
  assign level_low = (|status_d) && !mask;
  assign start     = (mode == IRQ_PULSE) && (|hits) && !mask && !busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(PULSE_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  assign pin_low = (mode == IRQ_PULSE) ? busy_d : level_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      irq_n_q  <= 1'b1;
    end else begin
      status_q <= status_d;
      busy_q   <= busy_d;
      cnt_q    <= cnt_d;
      irq_n_q  <= !pin_low;
    end
  end

  // R3: unmasked level pin follows the latched status word
  a_r3_level_pin: assert property (@(posedge clk) disable iff (rst)
    (!pulse_mode && !mask) |=> (irq_n_q == !(|status_q)));
  // R5: a masked level pin stays inactive
  a_r5_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (!pulse_mode && mask) |=> irq_n_q);
  // R4: an event colliding with a read survives it
  a_r4_read_collision: assert property (@(posedge clk) disable iff (rst)
    rd |=> ((status_q & $past(hits)) == $past(hits)));
  // R6: a pulse counts down one step per cycle while active
  a_r6_pulse_count: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
  // R7: a pulse ends when its count reaches zero, new events do not extend it
  a_r7_pulse_ends: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == '0) |=> !busy_q);
  // R6: in pulse mode the pin reflects the pulse state
  a_r6_pulse_pin: assert property (@(posedge clk) disable iff (rst)
    pulse_mode |=> (irq_n_q == !busy_q));
  // R8: a pulse only begins after an unmasked cycle
  a_r8_no_masked_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !$past(mask));
endmodule

// File: rtl/irqc_err.sv
module irqc_err #(
  parameter int NUM_ERR = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] cond,
  input  logic               rd,
  output logic [NUM_ERR-1:0] stat_q,
  output logic               err_n_q
);
  logic [NUM_ERR-1:0] cond_q, rise, stat_d;

  assign rise   = cond & ~cond_q;
  assign stat_d = ((stat_q & ~{NUM_ERR{rd}}) | rise) & cond;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q  <= '0;
      stat_q  <= '0;
      err_n_q <= 1'b1;
    end else begin
      cond_q  <= cond;
      stat_q  <= stat_d;
      err_n_q <= !(|stat_d);
    end
  end

  // R9: error pin is low exactly when status holds a bit
  a_r9_err_pin: assert property (@(posedge clk) disable iff (rst)
    err_n_q == !(|stat_q));
  // R10: no status bit survives the removal of its condition
  a_r10_clear_on_removal: assert property (@(posedge clk) disable iff (rst)
    (stat_q & ~$past(cond)) == '0);
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_COND     = 8,
  parameter int NUM_GP       = 3,
  parameter int NUM_ERR      = 4,
  parameter int PULSE_CYCLES = 16,
  parameter int MAP_W        = $clog2(NUM_GP + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_COND-1:0]        evt_strobe,
  input  logic [NUM_COND*MAP_W-1:0]  evt_map,
  input  logic [NUM_GP-1:0]          gp_pulse_mode,
  input  logic [NUM_GP-1:0]          gp_mask,
  input  logic [NUM_GP-1:0]          gp_stat_rd,
  input  logic [NUM_ERR-1:0]         err_cond,
  input  logic                       err_stat_rd,
  output logic [NUM_GP*NUM_COND-1:0] gp_status,
  output logic [NUM_ERR-1:0]         err_status,
  output logic [NUM_GP-1:0]          irq_n,
  output logic                       err_n
);
  logic [NUM_GP*NUM_COND-1:0] hits;

  irqc_router #(.NUM_COND(NUM_COND), .NUM_GP(NUM_GP), .MAP_W(MAP_W)) router_i (
    .evt  (evt_strobe),
    .map  (evt_map),
    .hits (hits)
  );

  for (genvar g = 0; g < NUM_GP; g++) begin : g_chan
    irqc_gp_chan #(.NUM_COND(NUM_COND), .PULSE_CYCLES(PULSE_CYCLES)) chan_i (
      .clk        (clk),
      .rst        (rst),
      .hits       (hits[g*NUM_COND +: NUM_COND]),
      .pulse_mode (gp_pulse_mode[g]),
      .mask       (gp_mask[g]),
      .rd         (gp_stat_rd[g]),
      .status_q   (gp_status[g*NUM_COND +: NUM_COND]),
      .irq_n_q    (irq_n[g])
    );
  end

  irqc_err #(.NUM_ERR(NUM_ERR)) err_i (
    .clk     (clk),
    .rst     (rst),
    .cond    (err_cond),
    .rd      (err_stat_rd),
    .stat_q  (err_status),
    .err_n_q (err_n)
  );

  // R2: each strobe reaches at most one pin
  a_r2_single_route: assert property (@(posedge clk) disable iff (rst)
    $countones(hits) <= $countones(evt_strobe));
  // R1: pins are inactive in the first cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (irq_n == '1 && err_n && gp_status == '0 && err_status == '0));
endmodule

// File: tb/irq_route_ctrl_tb_top.sv
module irq_route_ctrl_tb_top;
  localparam int NC = 4;
  localparam int NG = 3;
  localparam int NE = 3;
  localparam int PW = 5;
  localparam int MW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0]    evt_strobe = '0;
  logic [NC*MW-1:0] evt_map = '0;
  logic [NG-1:0]    gp_pulse_mode = '0;
  logic [NG-1:0]    gp_mask = '0;
  logic [NG-1:0]    gp_stat_rd = '0;
  logic [NE-1:0]    err_cond = '0;
  logic             err_stat_rd = 1'b0;
  logic [NG*NC-1:0] gp_status;
  logic [NE-1:0]    err_status;
  logic [NG-1:0]    irq_n;
  logic             err_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_route_ctrl #(.NUM_COND(NC), .NUM_GP(NG), .NUM_ERR(NE), .PULSE_CYCLES(PW)) dut_i (
    .clk(clk), .rst(rst), .evt_strobe(evt_strobe), .evt_map(evt_map),
    .gp_pulse_mode(gp_pulse_mode), .gp_mask(gp_mask), .gp_stat_rd(gp_stat_rd),
    .err_cond(err_cond), .err_stat_rd(err_stat_rd), .gp_status(gp_status),
    .err_status(err_status), .irq_n(irq_n), .err_n(err_n)
  );

  // {condition, routing code}
  localparam logic [7:0] MAP_VEC [6] = '{8'h01, 8'h12, 8'h23, 8'h30, 8'h32, 8'h03};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic route(input int c, input logic [MW-1:0] k);
    evt_map = '0;
    evt_map[c*MW +: MW] = k;
  endtask

  task automatic fire(input int c);
    evt_strobe[c] = 1'b1;
    @(negedge clk);
    evt_strobe = '0;
  endtask

  task automatic read_gp(input logic [NG-1:0] which);
    gp_stat_rd = which;
    @(negedge clk);
    gp_stat_rd = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int low;
    repeat (3) @(negedge clk);
    check("R1 irq_n in reset", 32'(irq_n), 32'h7);
    check("R1 err_n in reset", 32'(err_n), 32'h1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 gp_status after reset", 32'(gp_status), 32'h0);
    check("R1 err_status after reset", 32'(err_status), 32'h0);
    check("R1 irq_n after reset", 32'(irq_n), 32'h7);

    // R2 / R3 table walk, level mode, unmasked
    for (int v = 0; v < 6; v++) begin
      int c;
      int k;
      logic [NG*NC-1:0] exp_s;
      logic [NG-1:0] exp_p;
      c = int'(MAP_VEC[v][7:4]);
      k = int'(MAP_VEC[v][3:0]);
      exp_s = (k != 0) ? (12'(1) << ((k-1)*NC + c)) : '0;
      exp_p = (k != 0) ? ~(3'(1) << (k-1)) : 3'b111;
      route(c, MW'(k));
      fire(c);
      check("R2 status routing", 32'(gp_status), 32'(exp_s));
      check("R3 level pin low", 32'(irq_n), 32'(exp_p));
      read_gp(3'b111);
      check("R3 read clears status", 32'(gp_status), 32'h0);
      check("R3 pin released on read", 32'(irq_n), 32'h7);
    end

    // R4: event in the same cycle as the read
    evt_map = '0;
    evt_map[0 +: MW] = 2'd1;
    evt_map[MW +: MW] = 2'd1;
    fire(0);
    check("R4 first event latched", 32'(gp_status[NC-1:0]), 32'h1);
    gp_stat_rd = 3'b001;
    evt_strobe[1] = 1'b1;
    @(negedge clk);
    gp_stat_rd = '0;
    evt_strobe = '0;
    check("R4 colliding event kept", 32'(gp_status[NC-1:0]), 32'h2);
    check("R4 pin still low", 32'(irq_n), 32'h6);
    read_gp(3'b001);

    // R5: mask gates pin only
    gp_mask = 3'b010;
    route(2, 2'd2);
    fire(2);
    check("R5 status latches while masked", 32'(gp_status[2*NC-1:NC]), 32'h4);
    check("R5 pin held while masked", 32'(irq_n), 32'h7);
    @(negedge clk);
    check("R5 pin still held", 32'(irq_n), 32'h7);
    gp_mask = '0;
    @(negedge clk);
    check("R5 unmask fires pending level", 32'(irq_n), 32'h5);
    read_gp(3'b010);
    check("R5 pin released", 32'(irq_n), 32'h7);

    // R6: pulse length
    gp_pulse_mode = 3'b100;
    route(0, 2'd3);
    fire(0);
    low = 0;
    for (int i = 0; i < 12; i++) begin
      if (!irq_n[2]) low++;
      @(negedge clk);
    end
    check("R6 pulse length", 32'(low), 32'(PW));
    check("R6 status latches in pulse mode", 32'(gp_status[2*NC]), 32'h1);
    read_gp(3'b100);
    check("R6 pin high after pulse", 32'(irq_n), 32'h7);

    // R7: second event during pulse
    fire(0);
    low = 0;
    for (int i = 0; i < 12; i++) begin
      if (!irq_n[2]) low++;
      evt_strobe[0] = (i == 1);
      @(negedge clk);
    end
    evt_strobe = '0;
    check("R7 pulse not lengthened", 32'(low), 32'(PW));
    read_gp(3'b100);

    // R8: masked event in pulse mode
    gp_mask = 3'b100;
    fire(0);
    low = 0;
    for (int i = 0; i < 4; i++) begin
      if (!irq_n[2]) low++;
      @(negedge clk);
    end
    gp_mask = '0;
    for (int i = 0; i < 8; i++) begin
      if (!irq_n[2]) low++;
      @(negedge clk);
    end
    check("R8 no pulse from masked event", 32'(low), 32'h0);
    check("R8 status latched", 32'(gp_status[2*NC]), 32'h1);
    read_gp(3'b100);
    gp_pulse_mode = '0;

    // R9 / R10: error path, all gp masks set
    gp_mask = 3'b111;
    err_cond = 3'b001;
    @(negedge clk);
    check("R10 rise sets bit", 32'(err_status), 32'h1);
    check("R9 err pin low unmaskable", 32'(err_n), 32'h0);
    err_stat_rd = 1'b1;
    @(negedge clk);
    err_stat_rd = 1'b0;
    check("R10 read clears bit", 32'(err_status), 32'h0);
    check("R9 err pin released", 32'(err_n), 32'h1);
    err_cond = 3'b000;
    @(negedge clk);
    err_cond = 3'b010;
    @(negedge clk);
    check("R10 second bit set", 32'(err_status), 32'h2);
    err_cond = 3'b000;
    @(negedge clk);
    check("R10 removal clears bit", 32'(err_status), 32'h0);
    check("R9 err pin high after removal", 32'(err_n), 32'h1);
    err_stat_rd = 1'b1;
    err_cond = 3'b100;
    @(negedge clk);
    err_stat_rd = 1'b0;
    check("R10 rise kept across read", 32'(err_status), 32'h4);
    check("R9 err pin low", 32'(err_n), 32'h0);
    err_cond = 3'b000;
    @(negedge clk);
    check("R10 cleared on removal", 32'(err_status), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule